// File: doc/BRIEF.md
# Banked GPIO Port with Per-Pin Inversion

This block is one general-purpose I/O port that lives inside a logical-device bank of a configuration register space. Software reaches it through a plain register read/write interface. Three byte registers set the port up: a direction register, a data register and an inversion register. A port-enable bit and a drive-mode bit, each held in a shared bank register, complete the setup. The block turns this state into a per-pin output-enable and a per-pin output value for the pad ring, and it reads back the external pin levels.

The inversion register sits between the pins and the data register and works in both directions. On an output pin the level driven is the data bit XOR the inversion bit. On an input pin the data register reads the pin level XOR the inversion bit. The drive mode applies to the whole port. In push-pull mode every output pin is driven to its level. In open-drain mode only a low level is driven, and a high level releases the pin.

The pin count is a parameter, so a reduced port (for example 5 pins) can be built. Its missing bits read as zero and ignore writes. A slot parameter moves the three port registers to the second register group of the bank, so two ports can share one bank.

Top module: `gpio_bank_port`

## Requirements
- R1: After reset every implemented direction bit reads 1, the data-latch and inversion registers hold 0, the port is disabled and the mode bit is 0, so `pin_oe` is all zero.
- R2: A direction bit of 1 makes its pin an input, which is never driven. A direction bit of 0 makes its pin an output.
- R3: While the enable bit (address `0x30`, bit `EN_BIT`) is 0, `pin_oe` and `pin_out` are all zero, whatever the other registers hold.
- R4: The level of an output pin is its data-latch bit XOR its inversion bit.
- R5: Reading the data register returns, for every input pin, the sampled pin level XOR its inversion bit.
- R6: Reading the data register returns, for every output pin, the value last written to it.
- R7: When the mode bit (address `MODE_ADDR`, bit `MODE_BIT`) is 1 and the port is enabled, every output pin has `pin_oe` high and `pin_out` equal to its level.
- R8: When the mode bit is 0 and the port is enabled, an output pin has `pin_oe` high only when its level is 0. `pin_out` is then all zero.
- R9: Bits at or above `NPINS` in the direction, data and inversion registers read as zero, and writes to them are ignored.
- R10: The port registers decode at 0xE0 + 4·`PORT_SLOT`: offset 0 is direction, offset 1 is data, offset 2 is inversion. A read returns its data on `reg_rdata` on the clock edge that samples `reg_rd`. Addresses of the other slot are not decoded.
- R11: A write to an address the port does not decode changes no state. A read of such an address returns 0.
- R12: A read of the enable address or the mode address returns the stored bit in its own position, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address within the bank |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Read strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | NPINS | External pin levels |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |

## Verification
The hardest case to reach is a data-register read in which input pins and output pins are mixed and a non-zero inversion pattern is set. In that read, each bit comes from a different source depending on its direction. The stimulus sets a split direction (upper nibble in, lower nibble out), an inversion pattern that crosses the split, and a pin pattern, and then reads. A reduced-width, second-slot instance shares the same bus, so every write also exercises cross-slot decoding and the dropping of bits above the pin count.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DATA,
    SEL_INV,
    SEL_EN,
    SEL_MODE
  } gpio_reg_sel_e;

  // Mask of implemented pin bits in a byte register.
  function automatic logic [7:0] impl_mask(input int npins);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i < npins);
    return m;
  endfunction

  // A single control bit placed at its position in a byte.
  function automatic logic [7:0] place_bit(input logic b, input int pos);
    logic [7:0] v;
    v = '0;
    v[pos] = b;
    return v;
  endfunction

  // Pad level seen by the outside for a latched bit.
  function automatic logic pin_level(input logic data_b, input logic inv_b);
    return data_b ^ inv_b;
  endfunction

  // Output enable of one pin.
  function automatic logic pin_drive(input logic en, input logic dir_b,
                                     input logic push_pull, input logic level);
    return en & ~dir_b & (push_pull | ~level);
  endfunction

  // Data register read view: inputs show adjusted pin, outputs show latch.
  function automatic logic [7:0] data_view(input logic [7:0] dir,
                                           input logic [7:0] data,
                                           input logic [7:0] inv,
                                           input logic [7:0] pins);
    return (dir & (pins ^ inv)) | (~dir & data);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int          PORT_SLOT = 0,
  parameter logic [7:0]  EN_ADDR   = 8'h30,
  parameter logic [7:0]  MODE_ADDR = 8'h29
) (
  input  logic [7:0]    addr,
  output gpio_reg_sel_e sel
);

  localparam logic [7:0] GROUP_BASE = 8'(8'hE0 + 4 * PORT_SLOT);
  localparam logic [7:0] DIR_ADDR   = GROUP_BASE;
  localparam logic [7:0] DATA_ADDR  = 8'(GROUP_BASE + 8'd1);
  localparam logic [7:0] INV_ADDR   = 8'(GROUP_BASE + 8'd2);

  always_comb begin
    if (addr == DIR_ADDR)       sel = SEL_DIR;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
    else if (addr == INV_ADDR)  sel = SEL_INV;
    else if (addr == EN_ADDR)   sel = SEL_EN;
    else if (addr == MODE_ADDR) sel = SEL_MODE;
    else                        sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int EN_BIT   = 0,
  parameter int MODE_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  gpio_reg_sel_e sel,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  input  logic [7:0]    pin_lvl,
  output logic [7:0]    dir_q,
  output logic [7:0]    data_q,
  output logic [7:0]    inv_q,
  output logic          en_q,
  output logic          mode_q,
  output logic [7:0]    rdata
);

  localparam logic [7:0] IMPL = impl_mask(NPINS);

  logic [7:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= IMPL;
      data_q <= '0;
      inv_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR:  dir_q  <= wdata & IMPL;
        SEL_DATA: data_q <= wdata & IMPL;
        SEL_INV:  inv_q  <= wdata & IMPL;
        SEL_EN:   en_q   <= wdata[EN_BIT];
        SEL_MODE: mode_q <= wdata[MODE_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rd_mux = dir_q;
      SEL_DATA: rd_mux = data_view(dir_q, data_q, inv_q, pin_lvl) & IMPL;
      SEL_INV:  rd_mux = inv_q;
      SEL_EN:   rd_mux = place_bit(en_q, EN_BIT);
      SEL_MODE: rd_mux = place_bit(mode_q, MODE_BIT);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R10
  data_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DATA) |=> (data_q == ($past(wdata) & IMPL)));

  // R11
  unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(data_q) &&
      $stable(inv_q) && $stable(en_q) && $stable(mode_q)));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == SEL_NONE) |=> (rdata == 8'h00));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             en,
  input  logic             push_pull,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] data,
  input  logic [NPINS-1:0] inv,
  output logic [NPINS-1:0] oe,
  output logic [NPINS-1:0] out
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic level;
    logic drive;
    assign level  = pin_level(data[i], inv[i]);
    assign drive  = pin_drive(en, dir[i], push_pull, level);
    assign oe[i]  = drive;
    assign out[i] = drive & push_pull & level;
  end

endmodule

// File: rtl/gpio_bank_port.sv
module gpio_bank_port
  import gpio_bank_pkg::*;
#(
  parameter int         NPINS     = 8,
  parameter int         PORT_SLOT = 0,
  parameter logic [7:0] EN_ADDR   = 8'h30,
  parameter int         EN_BIT    = 0,
  parameter logic [7:0] MODE_ADDR = 8'h29,
  parameter int         MODE_BIT  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] pin_out
);

  localparam logic [7:0] IMPL = impl_mask(NPINS);

  gpio_reg_sel_e sel;
  logic [7:0]    pin_lvl;
  logic [7:0]    dir_q, data_q, inv_q;
  logic          en_q, mode_q;

  for (genvar i = 0; i < 8; i++) begin : g_pin_ext
    if (i < NPINS) begin : g_real
      assign pin_lvl[i] = pin_in[i];
    end else begin : g_absent
      assign pin_lvl[i] = 1'b0;
    end
  end

  gpio_addr_decode #(
    .PORT_SLOT (PORT_SLOT),
    .EN_ADDR   (EN_ADDR),
    .MODE_ADDR (MODE_ADDR)
  ) u_decode (
    .addr (reg_addr),
    .sel  (sel)
  );

  gpio_bank_regs #(
    .NPINS    (NPINS),
    .EN_BIT   (EN_BIT),
    .MODE_BIT (MODE_BIT)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .wdata   (reg_wdata),
    .pin_lvl (pin_lvl),
    .dir_q   (dir_q),
    .data_q  (data_q),
    .inv_q   (inv_q),
    .en_q    (en_q),
    .mode_q  (mode_q),
    .rdata   (reg_rdata)
  );

  gpio_pad_ctrl #(
    .NPINS (NPINS)
  ) u_pad (
    .en        (en_q),
    .push_pull (mode_q),
    .dir       (dir_q[NPINS-1:0]),
    .data      (data_q[NPINS-1:0]),
    .inv       (inv_q[NPINS-1:0]),
    .oe        (pin_oe),
    .out       (pin_out)
  );

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pin_oe == '0 && pin_out == '0));

  // R2
  input_never_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q[NPINS-1:0]) == '0);

  // R7
  push_pull_drives_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q) |-> (pin_oe == ~dir_q[NPINS-1:0]));

  // R8
  open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (pin_out == '0));

  // R9
  absent_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q | data_q | inv_q) & ~IMPL) == 8'h00);

endmodule

// File: tb/test_gpio_bank_port.sv
`timescale 1ns/1ps
module test_gpio_bank_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] pin_in_w = '0;
  logic [4:0] pin_in_n = '0;
  logic [7:0] rdata_w, oe_w, out_w;
  logic [7:0] rdata_n;
  logic [4:0] oe_n, out_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank_port i_gpio_bank_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rdata_w),
    .pin_in(pin_in_w), .pin_oe(oe_w), .pin_out(out_w)
  );

  // Reduced 5-pin port in the second register group, enable bit 1, mode bit 4.
  gpio_bank_port #(.NPINS(5), .PORT_SLOT(1), .EN_BIT(1), .MODE_BIT(4))
  i_gpio_bank_port_narrow (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
    .pin_in(pin_in_n), .pin_oe(oe_n), .pin_out(out_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 wide oe", oe_w, 8'h00);
    check("R1 narrow oe", {3'b0, oe_n}, 8'h00);
    rd(8'hE0); check("R1 wide dir", rdata_w, 8'hFF);
    rd(8'hE4); check("R1 narrow dir", rdata_n, 8'h1F);
    rd(8'hE2); check("R1 wide inv", rdata_w, 8'h00);
    pin_in_w = 8'hA5;
    rd(8'hE1); check("R5 wide data reads pins", rdata_w, 8'hA5);
    rd(8'h30); check("R1 enable clear", rdata_w, 8'h00);
  endtask

  task automatic t_enable_gate;
    wr(8'hE0, 8'h00);
    wr(8'hE1, 8'hFF);
    wr(8'h29, 8'h08);
    check("R3 disabled oe", oe_w, 8'h00);
    check("R3 disabled out", out_w, 8'h00);
    wr(8'h30, 8'h01);
    check("R7 enabled oe", oe_w, 8'hFF);
    check("R7 enabled out", out_w, 8'hFF);
  endtask

  task automatic t_direction;
    wr(8'hE0, 8'hF0);
    check("R2 split oe", oe_w, 8'h0F);
    check("R2 split out", out_w, 8'h0F);
    rd(8'hE0); check("R2 dir readback", rdata_w, 8'hF0);
  endtask

  task automatic t_inversion;
    wr(8'hE2, 8'h3C);
    check("R4 inverted out", out_w, 8'h03);
    pin_in_w = 8'h5A;
    rd(8'hE1); check("R6 mixed read", rdata_w, 8'h6F);
    wr(8'hE0, 8'hFF);
    check("R2 all inputs oe", oe_w, 8'h00);
    rd(8'hE1); check("R5 inverted pin read", rdata_w, 8'h66);
  endtask

  task automatic t_open_drain;
    wr(8'h29, 8'h00);
    wr(8'hE0, 8'h00);
    wr(8'hE2, 8'h00);
    wr(8'hE1, 8'hAA);
    check("R8 od oe", oe_w, 8'h55);
    check("R8 od out", out_w, 8'h00);
    wr(8'hE2, 8'h0F);
    check("R8 od inverted oe", oe_w, 8'h5A);
    check("R8 od inverted out", out_w, 8'h00);
  endtask

  task automatic t_narrow;
    wr(8'h30, 8'h02);
    wr(8'h29, 8'h10);
    wr(8'hE4, 8'h00);
    wr(8'hE5, 8'hFF);
    rd(8'hE5); check("R9 narrow data masked", rdata_n, 8'h1F);
    check("R7 narrow oe", {3'b0, oe_n}, 8'h1F);
    check("R7 narrow out", {3'b0, out_n}, 8'h1F);
    wr(8'hE6, 8'hE0);
    rd(8'hE6); check("R9 narrow inv absent bits", rdata_n, 8'h00);
    check("R9 narrow out unchanged", {3'b0, out_n}, 8'h1F);
    rd(8'hE4); check("R10 wide ignores other slot", rdata_w, 8'h00);
    rd(8'hE0);
    check("R10 wide dir kept", rdata_w, 8'h00);
    check("R10 narrow ignores slot 0", rdata_n, 8'h00);
    check("R3 wide disabled again", oe_w, 8'h00);
  endtask

  task automatic t_unmapped;
    wr(8'h31, 8'h55);
    rd(8'h31);
    check("R11 unmapped read wide", rdata_w, 8'h00);
    check("R11 unmapped read narrow", rdata_n, 8'h00);
    rd(8'hE1); check("R11 data unchanged", rdata_w, 8'hAA);
    rd(8'hE2); check("R11 inv unchanged", rdata_w, 8'h0F);
  endtask

  task automatic t_ctrl_bits;
    wr(8'h30, 8'hFF);
    rd(8'h30);
    check("R12 wide enable bit", rdata_w, 8'h01);
    check("R12 narrow enable bit", rdata_n, 8'h02);
    wr(8'h29, 8'hFF);
    rd(8'h29);
    check("R12 wide mode bit", rdata_w, 8'h08);
    check("R12 narrow mode bit", rdata_n, 8'h10);
    check("R7 wide pp oe", oe_w, 8'hFF);
    check("R7 wide pp out", out_w, 8'hA5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_gate();
    t_direction();
    t_inversion();
    t_open_drain();
    t_narrow();
    t_unmapped();
    t_ctrl_bits();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1-watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule